// File: doc/BRIEF.md
# Peripheral-Triggered Single-Channel DMA Engine

This block is one DMA channel that copies data items between a RAM buffer and a peripheral data register, one item per trigger. Software programs a peripheral register offset, a RAM address, an item count and a mode word, then enables and activates the channel. A software trigger bit starts the first item of the sequence. Each later item waits for a pulse on the hardware trigger input, for example a serial "transmit done" strobe.

Every item is a read from the source followed by a write to the destination over one shared request/ready memory port. The peripheral register lies in a fixed upper page of the address space. After the last item has been written, the channel raises a one-cycle completion interrupt and drops its active bit by itself.

Software can stop a sequence early. It clears the active bit, then clears the enable bit. After that the channel makes no further transfers and raises no interrupt.

Top module: `dma_chan`

## Requirements
- R1: After reset, done_irq and mem_req are 0, and the control and count registers read 0.
- R2: The registers read back what was written. Register addresses: 0 peripheral offset (8 bits), 1 RAM address, 2 count, 3 mode, 4 control. Mode bit 0 is the direction and mode bit 1 selects word size. Control bit 0 is enable, bit 1 is active and bit 2 is the go strobe, which reads 0.
- R3: After activation, only a control write with go=1 starts the first item. Hardware trigger pulses before that are ignored.
- R4: After the first item, each hardware trigger pulse starts exactly one item. Pulses are ignored and not queued while a transfer is in progress or while the channel is inactive or disabled.
- R5: Each item reads the source and then writes the value read to the destination. With direction 0 the source is the RAM address and the destination is 0xFF00 plus the offset. With direction 1 the two are swapped.
- R6: After each item, the RAM address advances by 1 (byte mode) or by 2 (word mode), wrapping at 16 bits, and the count decrements by 1.
- R7: The cycle after the final write is accepted, done_irq is high for exactly one cycle. Active reads 0 from that same cycle on.
- R8: A write to the enable bit is ignored while active is 1.
- R9: After software writes active=0 and then enable=0, no memory requests and no done_irq follow.
- R10: A starting count of 0 means 65536 items. After one item the count reads 0xFFFF and active stays 1.
- R11: A memory request holds its address, direction and data steady until mem_ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| hw_trig | input | 1 | Peripheral trigger pulse |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_word | output | 1 | 1 = word access, 0 = byte access |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |
| done_irq | output | 1 | Completion interrupt pulse |

## Verification
A wrong sequencer state shows up at the memory port within one item. It appears as a missing or extra request, a write to the wrong side, or data that does not match the value read. A wrong address or count register shows up as a wrong item address on the next item, or as a wrong readback once the sequence ends. A fault in the trigger gating or in the completion logic appears as a transfer count different from the programmed count. It can also appear as a done_irq that is missing, doubled or misplaced relative to the final write. This can be seen within a few cycles of the trigger or of the final write.

// File: rtl/dma_pkg.sv
package dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } seq_state_e;

  localparam logic [2:0] RA_POFF = 3'd0;
  localparam logic [2:0] RA_RAM  = 3'd1;
  localparam logic [2:0] RA_CNT  = 3'd2;
  localparam logic [2:0] RA_MODE = 3'd3;
  localparam logic [2:0] RA_CTRL = 3'd4;

  localparam int CTRL_EN   = 0;
  localparam int CTRL_ACT  = 1;
  localparam int CTRL_GO   = 2;
  localparam int MODE_DIR  = 0;
  localparam int MODE_WORD = 1;

endpackage

// File: rtl/dma_regs.sv
module dma_regs
  import dma_pkg::*;
#(
  parameter int REG_W = 16,
  parameter int AW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             step,
  output logic [OW-1:0]    poff,
  output logic [AW-1:0]    ram_addr,
  output logic             dir,
  output logic             word,
  output logic             enable,
  output logic             active,
  output logic             first_pend,
  output logic             sw_req,
  output logic             irq
);

  localparam logic [CW-1:0] CNT_ONE = CW'(1);
  localparam logic [AW-1:0] INC_B   = AW'(1);
  localparam logic [AW-1:0] INC_W   = AW'(2);

  logic [OW-1:0] poff_q, poff_d;
  logic [AW-1:0] ram_q, ram_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d, word_q, word_d;
  logic          en_q, en_d, act_q, act_d;
  logic          first_q, first_d, sw_q, sw_d, irq_q, irq_d;
  logic          wr_ctrl, last_item;

  assign wr_ctrl   = reg_wr && (reg_addr == RA_CTRL);
  assign last_item = (cnt_q == CNT_ONE);

  always_comb begin
    poff_d  = poff_q;
    ram_d   = ram_q;
    cnt_d   = cnt_q;
    dir_d   = dir_q;
    word_d  = word_q;
    en_d    = en_q;
    act_d   = act_q;
    first_d = first_q;
    sw_d    = 1'b0;
    irq_d   = step && last_item && act_q;

    if (reg_wr && reg_addr == RA_POFF) poff_d = reg_wdata[OW-1:0];
    if (reg_wr && reg_addr == RA_MODE) begin
      dir_d  = reg_wdata[MODE_DIR];
      word_d = reg_wdata[MODE_WORD];
    end

    if (reg_wr && reg_addr == RA_RAM) ram_d = reg_wdata[AW-1:0];
    else if (step) ram_d = ram_q + (word_q ? INC_W : INC_B);

    if (reg_wr && reg_addr == RA_CNT) cnt_d = reg_wdata[CW-1:0];
    else if (step) cnt_d = cnt_q - CNT_ONE;

    if (step) first_d = 1'b0;

    if (wr_ctrl) begin
      if (!act_q) en_d = reg_wdata[CTRL_EN];
      act_d = reg_wdata[CTRL_ACT] && en_d;
      if (!act_q && act_d) first_d = 1'b1;
      sw_d  = reg_wdata[CTRL_GO] && act_d;
    end

    if (step && last_item) act_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      poff_q  <= '0;
      ram_q   <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      word_q  <= 1'b0;
      en_q    <= 1'b0;
      act_q   <= 1'b0;
      first_q <= 1'b0;
      sw_q    <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      poff_q  <= poff_d;
      ram_q   <= ram_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
      word_q  <= word_d;
      en_q    <= en_d;
      act_q   <= act_d;
      first_q <= first_d;
      sw_q    <= sw_d;
      irq_q   <= irq_d;
    end
  end

  always_comb begin
    case (reg_addr)
      RA_POFF: reg_rdata = REG_W'(poff_q);
      RA_RAM:  reg_rdata = REG_W'(ram_q);
      RA_CNT:  reg_rdata = REG_W'(cnt_q);
      RA_MODE: reg_rdata = REG_W'({word_q, dir_q});
      RA_CTRL: reg_rdata = REG_W'({act_q, en_q});
      default: reg_rdata = '0;
    endcase
  end

  assign poff       = poff_q;
  assign ram_addr   = ram_q;
  assign dir        = dir_q;
  assign word       = word_q;
  assign enable     = en_q;
  assign active     = act_q;
  assign first_pend = first_q;
  assign sw_req     = sw_q;
  assign irq        = irq_q;

endmodule

// File: rtl/dma_seq.sv
module dma_seq
  import dma_pkg::*;
#(
  parameter int            AW          = 16,
  parameter int            DW          = 16,
  parameter int            OW          = 8,
  parameter logic [AW-OW-1:0] PERIPH_PAGE = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          active,
  input  logic          first_pend,
  input  logic          sw_req,
  input  logic          hw_trig,
  input  logic          dir,
  input  logic          word,
  input  logic [OW-1:0] poff,
  input  logic [AW-1:0] ram_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic          mem_word,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          step
);

  seq_state_e    st_q, st_d;
  logic [AW-1:0] src_q, src_d, dst_q, dst_d;
  logic [DW-1:0] data_q, data_d;
  logic          word_q, word_d;
  logic [AW-1:0] periph_addr;
  logic          start;

  assign periph_addr = {PERIPH_PAGE, poff};
  assign start = (st_q == ST_IDLE) && enable && active &&
                 (first_pend ? sw_req : hw_trig);

  always_comb begin
    st_d   = st_q;
    src_d  = src_q;
    dst_d  = dst_q;
    data_d = data_q;
    word_d = word_q;
    case (st_q)
      ST_IDLE: if (start) begin
        st_d   = ST_READ;
        src_d  = dir ? periph_addr : ram_addr;
        dst_d  = dir ? ram_addr : periph_addr;
        word_d = word;
      end
      ST_READ: if (mem_ready) begin
        data_d = mem_rdata;
        st_d   = ST_WRITE;
      end
      ST_WRITE: if (mem_ready) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      src_q  <= '0;
      dst_q  <= '0;
      data_q <= '0;
      word_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      src_q  <= src_d;
      dst_q  <= dst_d;
      data_q <= data_d;
      word_q <= word_d;
    end
  end

  assign mem_req   = (st_q != ST_IDLE);
  assign mem_we    = (st_q == ST_WRITE);
  assign mem_word  = word_q;
  assign mem_addr  = (st_q == ST_WRITE) ? dst_q : src_q;
  assign mem_wdata = data_q;
  assign step      = (st_q == ST_WRITE) && mem_ready;

endmodule

// File: rtl/dma_chan.sv
module dma_chan #(
  parameter int AW    = 16,
  parameter int DW    = 16,
  parameter int CW    = 16,
  parameter int OW    = 8,
  parameter int REG_W = 16,
  parameter logic [AW-OW-1:0] PERIPH_PAGE = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             hw_trig,
  output logic             mem_req,
  output logic             mem_we,
  output logic             mem_word,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  input  logic             mem_ready,
  output logic             done_irq
);

  logic [1:0]    rst_sync;
  logic          rst_q;
  logic [OW-1:0] poff_w;
  logic [AW-1:0] ram_w;
  logic          dir_w, word_w, en_w, act_w, first_w, sw_w, step_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q = rst_sync[1];

  dma_regs #(.REG_W(REG_W), .AW(AW), .CW(CW), .OW(OW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_q),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .step       (step_w),
    .poff       (poff_w),
    .ram_addr   (ram_w),
    .dir        (dir_w),
    .word       (word_w),
    .enable     (en_w),
    .active     (act_w),
    .first_pend (first_w),
    .sw_req     (sw_w),
    .irq        (done_irq)
  );

  dma_seq #(.AW(AW), .DW(DW), .OW(OW), .PERIPH_PAGE(PERIPH_PAGE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_q),
    .enable     (en_w),
    .active     (act_w),
    .first_pend (first_w),
    .sw_req     (sw_w),
    .hw_trig    (hw_trig),
    .dir        (dir_w),
    .word       (word_w),
    .poff       (poff_w),
    .ram_addr   (ram_w),
    .mem_ready  (mem_ready),
    .mem_rdata  (mem_rdata),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_word   (mem_word),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .step       (step_w)
  );

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          active,
  input logic          enable,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ready,
  input logic          done_irq
);

  assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  assert_irq_drops_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!active && $past(active)));

  assert_enable_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(active) |-> $stable(enable));

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  assert_idle_after_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !active && !mem_req) |=> !mem_req);

endmodule

bind dma_chan dma_chan_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q),
  .active    (act_w),
  .enable    (en_w),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .done_irq  (done_irq)
);

// File: tb/sim_dma_chan.sv
module sim_dma_chan;

  typedef struct packed {
    logic        dir;
    logic        word;
    logic [15:0] cnt;
    logic [15:0] ram;
    logic [7:0]  off;
    logic [1:0]  wt;
  } vec_t;

  localparam int NV = 4;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 16'd3, 16'h1000, 8'h44, 2'd0},
    '{1'b1, 1'b1, 16'd4, 16'h2002, 8'h10, 2'd1},
    '{1'b0, 1'b1, 16'd2, 16'hFFFE, 8'h80, 2'd2},
    '{1'b1, 1'b0, 16'd1, 16'h0300, 8'h00, 2'd0}
  };

  logic        clk, rst_n, reg_wr, hw_trig;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_word, mem_ready, done_irq;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;

  int checks, fails;
  int cyc, irq_cnt, irq_cyc, last_wr_cyc, n_rd, n_wr, wcnt, wait_cfg;
  logic irq_prev;
  logic [15:0] rd_log [8];
  logic [15:0] wa_log [8];
  logic [15:0] wd_log [8];

  dma_chan u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .hw_trig(hw_trig),
    .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .done_irq(done_irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [15:0] pat(input logic [15:0] a);
    return a ^ 16'hA55A;
  endfunction

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (done_irq) begin
      irq_cnt = irq_cnt + 1;
      irq_cyc = cyc;
      if (irq_prev) begin
        fails = fails + 1;
        $display("FAIL R7 done_irq wider than one cycle: actual=2 expected=1");
      end
    end
    irq_prev = done_irq;
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req) begin
      if (wcnt == wait_cfg) begin
        mem_ready = 1'b1;
        wcnt = 0;
        if (mem_we) begin
          if (n_wr < 8) begin wa_log[n_wr] = mem_addr; wd_log[n_wr] = mem_wdata; end
          n_wr = n_wr + 1;
          last_wr_cyc = cyc;
        end else begin
          if (n_rd < 8) rd_log[n_rd] = mem_addr;
          n_rd = n_rd + 1;
          mem_rdata = pat(mem_addr);
        end
      end else wcnt = wcnt + 1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_wr = 1'b0; reg_addr = 3'd4;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(posedge clk); #1;
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
    @(posedge clk); #1;
    reg_addr = 3'd4;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic trig();
    @(posedge clk); #1; hw_trig = 1'b1;
    @(posedge clk); #1; hw_trig = 1'b0;
  endtask

  task automatic clear_logs();
    n_rd = 0; n_wr = 0; irq_cnt = 0;
  endtask

  task automatic run_vec(input vec_t v);
    logic [15:0] r, rama, pa, step_sz;
    wait_cfg = int'(v.wt);
    clear_logs();
    wr(3'd0, {8'h00, v.off});
    wr(3'd1, v.ram);
    wr(3'd2, v.cnt);
    wr(3'd3, {14'd0, v.word, v.dir});
    wr(3'd4, 16'h0001);
    wr(3'd4, 16'h0007);
    idle(20);
    for (int i = 1; i < int'(v.cnt); i++) begin
      trig();
      idle(20);
    end
    step_sz = v.word ? 16'd2 : 16'd1;
    pa = 16'hFF00 | {8'h00, v.off};
    chk(n_wr == int'(v.cnt), "R4 item count", n_wr, v.cnt);
    for (int i = 0; i < int'(v.cnt) && i < 8; i++) begin
      rama = v.ram + step_sz * 16'(i);
      chk(rd_log[i] == (v.dir ? pa : rama), "R5 source address", rd_log[i], v.dir ? pa : rama);
      chk(wa_log[i] == (v.dir ? rama : pa), "R6 destination address", wa_log[i], v.dir ? rama : pa);
      chk(wd_log[i] == pat(v.dir ? pa : rama), "R5 data moved", wd_log[i], pat(v.dir ? pa : rama));
    end
    chk(irq_cnt == 1, "R7 irq count", irq_cnt, 1);
    chk(irq_cyc == last_wr_cyc + 1, "R7 irq timing", irq_cyc, last_wr_cyc + 1);
    rd(3'd2, r);
    chk(r == 16'd0, "R6 final count", r, 0);
    rd(3'd1, r);
    chk(r == 16'(v.ram + step_sz * v.cnt), "R6 final RAM address", r, 16'(v.ram + step_sz * v.cnt));
    rd(3'd4, r);
    chk(r == 16'h0001, "R7 active cleared, enable kept", r, 16'h0001);
  endtask

  initial begin
    logic [15:0] r;
    int base;
    checks = 0; fails = 0; cyc = 0; irq_cnt = 0; irq_cyc = 0; last_wr_cyc = 0;
    n_rd = 0; n_wr = 0; wcnt = 0; wait_cfg = 0; irq_prev = 1'b0;
    mem_ready = 1'b0; mem_rdata = '0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd4; reg_wdata = '0; hw_trig = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(5);

    // R1 reset state
    chk(done_irq == 1'b0, "R1 done_irq", done_irq, 0);
    chk(mem_req == 1'b0, "R1 mem_req", mem_req, 0);
    rd(3'd4, r); chk(r == 16'h0, "R1 control", r, 0);
    rd(3'd2, r); chk(r == 16'h0, "R1 count", r, 0);

    // R2 readback
    wr(3'd0, 16'h005C); rd(3'd0, r); chk(r == 16'h005C, "R2 offset", r, 16'h005C);
    wr(3'd1, 16'hBEEF); rd(3'd1, r); chk(r == 16'hBEEF, "R2 RAM address", r, 16'hBEEF);
    wr(3'd2, 16'h0123); rd(3'd2, r); chk(r == 16'h0123, "R2 count", r, 16'h0123);
    wr(3'd3, 16'h0003); rd(3'd3, r); chk(r == 16'h0003, "R2 mode", r, 16'h0003);

    // table walk: R4 R5 R6 R7
    for (int k = 0; k < NV; k++) run_vec(VECS[k]);

    // R3: hardware trigger before go is ignored
    wait_cfg = 0; clear_logs();
    wr(3'd0, 16'h0020); wr(3'd1, 16'h4000); wr(3'd2, 16'd2); wr(3'd3, 16'h0000);
    wr(3'd4, 16'h0001); wr(3'd4, 16'h0003);
    trig(); idle(10);
    chk(n_rd == 0, "R3 trigger before go ignored", n_rd, 0);
    wr(3'd4, 16'h0007); idle(10);
    chk(n_wr == 1, "R3 go starts first item", n_wr, 1);
    // R4: trigger during a transfer is not queued
    @(posedge clk); #1; hw_trig = 1'b1;
    @(posedge clk); #1;
    @(posedge clk); #1; hw_trig = 1'b0;
    idle(15);
    chk(n_wr == 2, "R4 busy trigger ignored", n_wr, 2);
    chk(irq_cnt == 1, "R4 sequence done once", irq_cnt, 1);
    trig(); idle(10);
    chk(n_rd == 2, "R4 trigger while inactive ignored", n_rd, 2);

    // R8 then R9
    clear_logs();
    wr(3'd2, 16'd3); wr(3'd4, 16'h0007); idle(10);
    wr(3'd4, 16'h0002);
    rd(3'd4, r); chk(r == 16'h0003, "R8 enable write ignored while active", r, 16'h0003);
    wr(3'd4, 16'h0001); wr(3'd4, 16'h0000);
    rd(3'd4, r); chk(r == 16'h0000, "R9 control after abort", r, 0);
    base = n_rd;
    trig(); idle(10); trig(); idle(10);
    chk(n_rd == base, "R9 no transfer after abort", n_rd, base);
    chk(irq_cnt == 0, "R9 no irq after abort", irq_cnt, 0);

    // R10 zero count means 65536
    clear_logs();
    wr(3'd2, 16'd0); wr(3'd4, 16'h0001); wr(3'd4, 16'h0007); idle(10);
    rd(3'd2, r); chk(r == 16'hFFFF, "R10 count after one item", r, 16'hFFFF);
    rd(3'd4, r); chk(r == 16'h0003, "R10 still active", r, 16'h0003);
    chk(irq_cnt == 0, "R10 no early irq", irq_cnt, 0);
    wr(3'd4, 16'h0001); wr(3'd4, 16'h0000);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails = fails + 1;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule